// File: doc/BRIEF.md
# Synthesizer Power-Up Programming Sequencer

This block programs a fractional-N frequency synthesizer over its three-wire serial port after power-up. A single start pulse makes it wait through a start-up delay and then send six 24-bit control words from a parameter table. Each word goes out most significant bit first and is then committed by a latch-enable pulse. The two low bits of every word name the synthesizer register that the word is written to.

The order of the words is fixed. Test modes are cleared first, then the noise and spur mode is chosen. Next the counters are held in reset through the control register, both dividers are loaded, and finally the counter reset is released. All bit timing comes from one divider. Every half-period of the serial clock, and every latch pulse, lasts `HALF_CYCLES` system clocks. The start-up wait is `STARTUP_TICKS` of these half-periods.

Top module: `syn_init_seq`

## Requirements
- R1: After a synchronous reset, `ser_clk` is 1, `ser_le` is 1, `ser_data` is 0, and `busy` and `done` are 0.
- R2: In idle, a start pulse raises `busy` on the next clock edge. The lines keep their idle levels for exactly `STARTUP_TICKS*HALF_CYCLES` cycles, after which `ser_clk` falls for the first bit.
- R3: Each word is 24 bits long and is sent MSB first. Exactly 24 rising `ser_clk` edges occur per word, and `ser_data` stays stable while `ser_clk` is high.
- R4: `ser_le` is low at every rising `ser_clk` edge. After the last bit it rises only while `ser_clk` is low, and then returns low.
- R5: Every high half of `ser_clk` during shifting lasts `HALF_CYCLES` cycles, and every latch pulse (`ser_le` high while `ser_clk` low) lasts `HALF_CYCLES` cycles.
- R6: The words go out in this order: 0x000003, 0x000383, 0x0017C6, 0x144191, 0x248118, 0x0017C2. Their bits [1:0] (the register select) therefore run 3, 3, 2, 1, 0, 2.
- R7: Bits [23:2] of the first word are all zero, which clears the test modes. The third and sixth words differ only in bit 2. That bit is 1 in the third word (counters held in reset) and 0 in the sixth word (counters released).
- R8: A start pulse while `busy` is high has no effect. The sequence still sends exactly six words, and `busy` lasts `(STARTUP_TICKS+6*51)*HALF_CYCLES` cycles.
- R9: `done` is a one-cycle pulse. It is raised on the edge where `busy` falls, after the sixth latch pulse and a trailing low half-period.
- R10: Whenever `busy` is 0, the lines sit at their idle levels. A start after `done` runs the full sequence again from the first word.
- R11: A reset during a sequence returns the block to idle, and the next start begins again from the first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Single-cycle request to run the programming sequence |
| ser_clk | output | 1 | Serial clock to the synthesizer, idles high |
| ser_data | output | 1 | Serial data, valid before each rising `ser_clk` edge |
| ser_le | output | 1 | Latch enable, low while shifting, pulsed high to commit a word |
| busy | output | 1 | High while a sequence is running |
| done | output | 1 | One-cycle pulse at the end of the sequence |

## Verification
The bench builds the block with `HALF_CYCLES` = 3 and `STARTUP_TICKS` = 4. A whole sequence then fits in 930 cycles, so repeated runs, start pulses during a run, and resets during a run all fit in a short bench. A divider value above 1 selects the counting tick generator. It also lets a bench monitor measure each serial half-period and latch pulse in whole cycles. The defaults keep the six-word table, so every received word, register select and counter-reset bit is checked against its required value.

// File: rtl/syn_init_pkg.sv
package syn_init_pkg;

   localparam int STEP_BITS  = 24;
   localparam int STEP_COUNT = 6;

   // Step i sits at bits [i*24 +: 24]; step 0 goes out first.
   localparam logic [STEP_COUNT*STEP_BITS-1:0] DEFAULT_STEPS = {
      24'h0017C2,   // control register, counter reset released
      24'h248118,   // N divider
      24'h144191,   // R divider
      24'h0017C6,   // control register, counter reset held
      24'h000383,   // noise/spur mode selection
      24'h000003    // noise/spur register cleared (test modes off)
   };

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_WAIT,
      PH_BIT_LO,
      PH_BIT_HI,
      PH_TAIL,
      PH_LATCH,
      PH_GAP
   } seq_phase_t;

endpackage

// File: rtl/syn_init_tick.sv
module syn_init_tick #(
   parameter int HALF_CYCLES = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic tick
);

   if (HALF_CYCLES < 1) begin : g_bad_half
      $error("syn_init_tick: HALF_CYCLES must be at least 1");
   end

   if (HALF_CYCLES == 1) begin : g_every_cycle
      assign tick = run;
   end else begin : g_counted
      localparam int CW = $clog2(HALF_CYCLES);
      localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
         if (rst || !run) begin
            cnt <= '0;
         end else if (cnt == LAST) begin
            cnt <= '0;
         end else begin
            cnt <= cnt + CW'(1);
         end
      end

      assign tick = run && (cnt == LAST);

      assert_tick_idle_R5: assert property (@(posedge clk) disable iff (rst)
         !run |=> (cnt == '0));
   end

endmodule

// File: rtl/syn_init_words.sv
module syn_init_words #(
   parameter int WORD_W    = 24,
   parameter int NUM_WORDS = 6,
   parameter int IW        = 3,
   parameter logic [NUM_WORDS*WORD_W-1:0] TABLE = '0
) (
   input  logic [IW-1:0]     idx,
   output logic [WORD_W-1:0] word
);

   logic [WORD_W-1:0] slot [NUM_WORDS];

   for (genvar g = 0; g < NUM_WORDS; g++) begin : g_slot
      assign slot[g] = TABLE[g*WORD_W +: WORD_W];
   end

   always_comb begin
      word = '0;
      for (int i = 0; i < NUM_WORDS; i++) begin
         if (int'(idx) == i) word = slot[i];
      end
   end

endmodule

// File: rtl/syn_init_shift.sv
module syn_init_shift #(
   parameter int WORD_W = 24
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [WORD_W-1:0] load_word,
   input  logic              shift,
   output logic              msb_next,
   output logic              last
);

   localparam int BW = $clog2(WORD_W);

   if (WORD_W < 3) begin : g_bad_width
      $error("syn_init_shift: WORD_W must be at least 3");
   end

   logic [WORD_W-1:0] sreg;
   logic [BW-1:0]     bcnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         sreg <= '0;
         bcnt <= '0;
      end else if (load) begin
         sreg <= load_word;
         bcnt <= BW'(WORD_W - 1);
      end else if (shift) begin
         sreg <= {sreg[WORD_W-2:0], 1'b0};
         bcnt <= bcnt - BW'(1);
      end
   end

   assign last = (bcnt == '0);

   always_comb begin
      if (load)       msb_next = load_word[WORD_W-1];
      else if (shift) msb_next = sreg[WORD_W-2];
      else            msb_next = sreg[WORD_W-1];
   end

   assert_no_shift_past_lsb_R3: assert property (@(posedge clk) disable iff (rst)
      shift |-> (bcnt != '0));

endmodule

// File: rtl/syn_init_seq.sv
module syn_init_seq
   import syn_init_pkg::*;
#(
   parameter int WORD_W        = STEP_BITS,
   parameter int NUM_WORDS     = STEP_COUNT,
   parameter int HALF_CYCLES   = 4,
   parameter int STARTUP_TICKS = 1000,
   parameter logic [NUM_WORDS*WORD_W-1:0] WORD_TABLE = DEFAULT_STEPS
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic ser_clk,
   output logic ser_data,
   output logic ser_le,
   output logic busy,
   output logic done
);

   localparam int IW = $clog2(NUM_WORDS + 1);
   localparam int DW = $clog2(STARTUP_TICKS + 1);
   localparam logic [IW-1:0] LAST_IDX  = IW'(NUM_WORDS - 1);
   localparam logic [DW-1:0] LAST_WAIT = DW'(STARTUP_TICKS - 1);

   if (NUM_WORDS < 1) begin : g_bad_count
      $error("syn_init_seq: NUM_WORDS must be at least 1");
   end
   if (STARTUP_TICKS < 1) begin : g_bad_startup
      $error("syn_init_seq: STARTUP_TICKS must be at least 1");
   end

   seq_phase_t        phase, phase_d;
   logic [IW-1:0]     widx, rom_idx;
   logic [DW-1:0]     wcnt;
   logic [WORD_W-1:0] rom_word;
   logic              tick, load, shift, msb_next, bit_last, final_word;

   syn_init_tick #(.HALF_CYCLES(HALF_CYCLES)) u_tick (
      .clk  (clk),
      .rst  (rst),
      .run  (phase != PH_IDLE),
      .tick (tick)
   );

   assign rom_idx = (phase == PH_GAP) ? widx + IW'(1) : widx;

   syn_init_words #(
      .WORD_W    (WORD_W),
      .NUM_WORDS (NUM_WORDS),
      .IW        (IW),
      .TABLE     (WORD_TABLE)
   ) u_words (
      .idx  (rom_idx),
      .word (rom_word)
   );

   syn_init_shift #(.WORD_W(WORD_W)) u_shift (
      .clk       (clk),
      .rst       (rst),
      .load      (load),
      .load_word (rom_word),
      .shift     (shift),
      .msb_next  (msb_next),
      .last      (bit_last)
   );

   assign final_word = (widx == LAST_IDX);

   always_comb begin
      phase_d = phase;
      load    = 1'b0;
      shift   = 1'b0;
      case (phase)
         PH_IDLE:   if (start) phase_d = PH_WAIT;
         PH_WAIT:   if (tick && wcnt == LAST_WAIT) begin
                       phase_d = PH_BIT_LO;
                       load    = 1'b1;
                    end
         PH_BIT_LO: if (tick) phase_d = PH_BIT_HI;
         PH_BIT_HI: if (tick) begin
                       if (bit_last) begin
                          phase_d = PH_TAIL;
                       end else begin
                          phase_d = PH_BIT_LO;
                          shift   = 1'b1;
                       end
                    end
         PH_TAIL:   if (tick) phase_d = PH_LATCH;
         PH_LATCH:  if (tick) phase_d = PH_GAP;
         PH_GAP:    if (tick) begin
                       if (final_word) begin
                          phase_d = PH_IDLE;
                       end else begin
                          phase_d = PH_BIT_LO;
                          load    = 1'b1;
                       end
                    end
         default:   phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase    <= PH_IDLE;
         widx     <= '0;
         wcnt     <= '0;
         busy     <= 1'b0;
         done     <= 1'b0;
         ser_clk  <= 1'b1;
         ser_le   <= 1'b1;
         ser_data <= 1'b0;
      end else begin
         phase <= phase_d;
         done  <= (phase == PH_GAP) && tick && final_word;

         if (phase == PH_IDLE) begin
            widx <= '0;
            wcnt <= '0;
         end else begin
            if (phase == PH_WAIT && tick) wcnt <= wcnt + DW'(1);
            if (phase == PH_GAP && tick && !final_word) widx <= widx + IW'(1);
         end

         busy     <= (phase_d != PH_IDLE);
         ser_clk  <= !(phase_d inside {PH_BIT_LO, PH_TAIL, PH_LATCH, PH_GAP});
         ser_le   <= (phase_d inside {PH_IDLE, PH_WAIT, PH_LATCH});
         ser_data <= (phase_d inside {PH_BIT_LO, PH_BIT_HI}) && msb_next;
      end
   end

   assert_idle_lines_R10: assert property (@(posedge clk) disable iff (rst)
      !busy |-> (ser_clk && ser_le && !ser_data));

   assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> $past(start));

   assert_data_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy) && ser_clk && $past(ser_clk)) |-> $stable(ser_data));

   assert_le_low_on_rise_R4: assert property (@(posedge clk) disable iff (rst)
      (busy && $rose(ser_clk)) |-> !ser_le);

   assert_latch_clk_low_R4: assert property (@(posedge clk) disable iff (rst)
      (busy && $rose(ser_le)) |-> !ser_clk);

   assert_done_at_busy_fall_R9: assert property (@(posedge clk) disable iff (rst)
      done |-> (!busy && $past(busy)));

   assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

endmodule

// File: tb/syn_init_seq_tb.sv
module syn_init_seq_tb;

   localparam int H = 3;
   localparam int S = 4;
   localparam int BUSY_LEN = (S + 6 * 51) * H;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start = 1'b0;
   logic ser_clk, ser_data, ser_le, busy, done;

   always #4 clk = ~clk;   // 125 MHz

   syn_init_seq #(.HALF_CYCLES(H), .STARTUP_TICKS(S)) u_dut (
      .clk(clk), .rst(rst), .start(start),
      .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
      .busy(busy), .done(done)
   );

   int checks = 0;
   int fails  = 0;

   logic [23:0] exp_words [6] = '{24'h000003, 24'h000383, 24'h0017C6,
                                  24'h144191, 24'h248118, 24'h0017C2};

   // Line monitor
   logic        mon_clr = 1'b0;
   logic [23:0] rx_sh;
   logic [23:0] rx_words [16];
   int          rx_bits  [16];
   int wcnt, bits, busy_cyc, lat, hrun, lrun;
   int half_err, lpw_err, le_rise_err, done_cnt, done_err;
   bit seen_fall;
   logic p_clk = 1'b1, p_le = 1'b1, p_busy = 1'b0, p_done = 1'b0;

   task automatic mon_reset();
      wcnt = 0; bits = 0; busy_cyc = 0; lat = 0; hrun = 0; lrun = 0;
      half_err = 0; lpw_err = 0; le_rise_err = 0; done_cnt = 0; done_err = 0;
      seen_fall = 1'b0; rx_sh = '0;
   endtask

   initial mon_reset();

   always @(negedge clk) begin
      if (mon_clr) begin
         mon_reset();
      end else begin
         if (busy) busy_cyc++;
         if (busy && !seen_fall && ser_clk) lat++;
         if (!p_clk && ser_clk && busy) begin
            rx_sh = {rx_sh[22:0], ser_data};
            bits++;
            if (ser_le) le_rise_err++;
         end
         if (p_clk && !ser_clk) begin
            if (hrun != 0 && hrun != H) half_err++;
            hrun = 0;
         end
         if (ser_clk && busy && seen_fall) hrun++;
         if (busy && !ser_clk) seen_fall = 1'b1;
         if (p_le && !ser_le) begin
            if (lrun != 0 && lrun != H) lpw_err++;
            lrun = 0;
         end
         if (ser_le && !ser_clk && busy) lrun++;
         if (!p_le && ser_le && busy) begin
            if (wcnt < 16) begin
               rx_words[wcnt] = rx_sh;
               rx_bits[wcnt]  = bits;
            end
            wcnt++;
            bits = 0;
         end
         if (done) begin
            done_cnt++;
            if (busy || !p_busy || p_done) done_err++;
         end
      end
      p_clk = ser_clk; p_le = ser_le; p_busy = busy; p_done = done;
   end

   task automatic check(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic clear_mon();
      @(posedge clk); mon_clr = 1'b1;
      @(posedge clk); mon_clr = 1'b0;
   endtask

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic wait_done();
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (done) break;
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic check_sequence(input string tag);
      check(wcnt == 6, {tag, " R6 word count"}, wcnt, 6);
      for (int k = 0; k < 6; k++) begin
         check(rx_words[k] == exp_words[k], {tag, " R6 word value"}, rx_words[k], exp_words[k]);
         check(rx_bits[k] == 24, {tag, " R3 bits per word"}, rx_bits[k], 24);
      end
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check(ser_clk && ser_le && !ser_data && !busy && !done, "R1 reset levels",
            {ser_clk, ser_le, ser_data, busy, done}, 5'b11000);
      rst = 1'b0;
      repeat (2) @(negedge clk);
      check(!busy && ser_clk && ser_le, "R1 idle after release", {busy, ser_clk, ser_le}, 3'b011);
   endtask

   task automatic t_full_run();
      clear_mon();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      check(busy == 1'b1, "R2 busy after start", busy, 1);
      wait_done();
      check(lat == S * H, "R2 startup latency", lat, S * H);
      check_sequence("full");
      check(rx_words[0][23:2] == '0, "R7 test-mode clear data", rx_words[0], 0);
      check((rx_words[2] ^ rx_words[5]) == 24'h4 && rx_words[2][2],
            "R7 counter reset bit", rx_words[2] ^ rx_words[5], 4);
      check({rx_words[0][1:0], rx_words[1][1:0], rx_words[2][1:0],
             rx_words[3][1:0], rx_words[4][1:0], rx_words[5][1:0]} == 12'b11_11_10_01_00_10,
            "R6 register select order", rx_words[4][1:0], 0);
      check(le_rise_err == 0, "R4 le low at clock rise", le_rise_err, 0);
      check(half_err == 0, "R5 clock half period", half_err, 0);
      check(lpw_err == 0, "R5 latch pulse width", lpw_err, 0);
      check(done_cnt == 1 && done_err == 0, "R9 done pulse", done_cnt, 1);
      check(busy_cyc == BUSY_LEN, "R9 busy length", busy_cyc, BUSY_LEN);
      check(ser_clk && ser_le && !ser_data, "R10 idle levels after done",
            {ser_clk, ser_le, ser_data}, 3'b110);
   endtask

   task automatic t_start_while_busy();
      clear_mon();
      pulse_start();
      repeat (5) @(negedge clk);
      pulse_start();
      repeat (200) @(negedge clk);
      pulse_start();
      repeat (400) @(negedge clk);
      pulse_start();
      wait_done();
      check_sequence("busy-start R8");
      check(busy_cyc == BUSY_LEN, "R8 busy length unchanged", busy_cyc, BUSY_LEN);
      repeat (60) @(negedge clk);
      check(wcnt == 6 && !busy, "R8 no extra run", wcnt, 6);
   endtask

   task automatic t_rerun();
      clear_mon();
      pulse_start();
      wait_done();
      check_sequence("rerun R10");
      check(done_cnt == 1, "R10 rerun done", done_cnt, 1);
   endtask

   task automatic t_reset_mid();
      clear_mon();
      pulse_start();
      repeat (300) @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check(!busy && ser_clk && ser_le && !ser_data, "R11 idle after mid reset",
            {busy, ser_clk, ser_le, ser_data}, 4'b0110);
      clear_mon();
      pulse_start();
      wait_done();
      check_sequence("restart R11");
      check(rx_words[0] == exp_words[0], "R11 restart from first word", rx_words[0], exp_words[0]);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      t_reset();
      t_full_run();
      t_start_while_busy();
      t_rerun();
      t_reset_mid();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule